// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregation Controller

This block gathers interrupt events from three source groups (display, graphics engine and power management) and turns them into a single CPU interrupt. Each group has a sticky status register and an enable register. The block reduces all enabled pending bits to one combined level. A master enable qualifies only the graphics and power groups. The display group reaches the combined level through its own enable register alone.

The CPU interrupt is a one-cycle pulse. It is produced only when the registered combined level goes from low to high. An interrupt handler that cannot clear every pending bit in one pass therefore has to force the level low. It does this by dropping the master enable and the display enable together, then restoring them, so that the leftover bits make a fresh edge.

Software uses a small word-addressed port. It can read status, enable and control registers, acknowledge status by writing ones, and read a per-group summary.

Top module: `irq_edge_aggregator`

## Requirements
- R1: The combined level is high when any display status bit is set together with its display enable bit, or when any enabled graphics or power status bit is set while the master bit is 1. A status bit that is set but not enabled raises no interrupt.
- R2: The master bit (bit 31 of the control word at offset 6) gates only the graphics and power groups. Enabled display status raises the level whether the master bit is 0 or 1.
- R3: `cpu_irq` is high for exactly one cycle, in the second cycle after the clock edge that makes the level true. A level that stays high produces no further pulse.
- R4: A status bit sets on its event pulse whether or not it is enabled. It stays set until software writes a 1 to that bit position of its status register: offset 0 for display, 2 for graphics, 4 for power. A 0 written to a status bit leaves it unchanged.
- R5: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Writing 0 to the master bit and 0 to the display enable (offset 1) forces the level low. If enabled status remains when the two are restored, exactly one new pulse follows, whichever of the two is restored first.
- R7: The control word at offset 6 reads the master bit at bit 31 and per-group enabled-pending summary bits at bits 0 (display), 1 (graphics) and 2 (power), with the summary not gated by master. Offset 7 returns the same summary with bit 31 reading 0. Writing 0 to offset 6 clears the master bit.
- R8: After reset all status, enable and master bits are 0 and no interrupt pulse occurs.
- R9: The enable registers sit at offsets 1, 3 and 5 and are read/write over the group width. Bits above a group's width read 0. Read data appears on `reg_rdata` one cycle after a read strobe. Writes to offset 7 and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_evt | input | DISP_W | One-cycle display event pulses |
| gfx_evt | input | GFX_W | One-cycle graphics-engine event pulses |
| pwr_evt | input | PWR_W | One-cycle power-management event pulses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| cpu_irq | output | 1 | One-cycle CPU interrupt pulse |

## Verification
Two functions can land on the same status bit in the same cycle: the sticky set from an event and the acknowledge from a write of ones. The bench provokes this by driving the event pulse and the clearing write on the same clock edge, then reads the status register to confirm that the bit survived. The handler masking sequence is run twice, restoring the master bit first in one run and the display enable first in the other. Each run is judged by a count of exactly one new pulse.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned MAXW = 32;

  localparam int unsigned OFF_DISP_STAT = 0;
  localparam int unsigned OFF_DISP_EN   = 1;
  localparam int unsigned OFF_GFX_STAT  = 2;
  localparam int unsigned OFF_GFX_EN    = 3;
  localparam int unsigned OFF_PWR_STAT  = 4;
  localparam int unsigned OFF_PWR_EN    = 5;
  localparam int unsigned OFF_CTRL      = 6;
  localparam int unsigned OFF_PEEK      = 7;

  // Sticky status update: acknowledge clears, a new event wins over it.
  function automatic logic [MAXW-1:0] sticky_next(input logic [MAXW-1:0] cur,
                                                  input logic [MAXW-1:0] clr,
                                                  input logic [MAXW-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Display is ungated; graphics and power share the master qualifier.
  function automatic logic combine_level(input logic disp_p, input logic gfx_p,
                                         input logic pwr_p, input logic master);
    return disp_p | ((gfx_p | pwr_p) & master);
  endfunction
endpackage

// File: rtl/irqagg_grp.sv
module irqagg_grp
  import irqagg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_d_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, en_q, stat_d;

  assign stat_d = W'(sticky_next(MAXW'(stat_q), MAXW'(clr_i), MAXW'(evt_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_q,
  output logic lvl_prev_q,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_q      <= lvl_i;
      lvl_prev_q <= lvl_q;
    end
  end

  assign irq_o = lvl_q & ~lvl_prev_q;
endmodule

// File: rtl/irqagg_regport.sv
module irqagg_regport
  import irqagg_pkg::*;
#(
  parameter int unsigned DISP_W = 8,
  parameter int unsigned GFX_W  = 8,
  parameter int unsigned PWR_W  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DISP_W-1:0] disp_stat,
  input  logic [DISP_W-1:0] disp_en,
  input  logic [GFX_W-1:0]  gfx_stat,
  input  logic [GFX_W-1:0]  gfx_en,
  input  logic [PWR_W-1:0]  pwr_stat,
  input  logic [PWR_W-1:0]  pwr_en,
  input  logic [2:0]        pend_sum,
  output logic [DISP_W-1:0] disp_clr,
  output logic [GFX_W-1:0]  gfx_clr,
  output logic [PWR_W-1:0]  pwr_clr,
  output logic              disp_en_we,
  output logic              gfx_en_we,
  output logic              pwr_en_we,
  output logic              master_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned MBIT = DATA_W - 1;

  logic              hit_dstat, hit_gstat, hit_pstat, hit_ctrl;
  logic [DATA_W-1:0] rd_mux, rdata_q, sum_word;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  assign hit_dstat  = wr_en && (addr == ADDR_W'(OFF_DISP_STAT));
  assign hit_gstat  = wr_en && (addr == ADDR_W'(OFF_GFX_STAT));
  assign hit_pstat  = wr_en && (addr == ADDR_W'(OFF_PWR_STAT));
  assign hit_ctrl   = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign disp_en_we = wr_en && (addr == ADDR_W'(OFF_DISP_EN));
  assign gfx_en_we  = wr_en && (addr == ADDR_W'(OFF_GFX_EN));
  assign pwr_en_we  = wr_en && (addr == ADDR_W'(OFF_PWR_EN));

  assign disp_clr = hit_dstat ? wdata[DISP_W-1:0] : '0;
  assign gfx_clr  = hit_gstat ? wdata[GFX_W-1:0]  : '0;
  assign pwr_clr  = hit_pstat ? wdata[PWR_W-1:0]  : '0;

  assign sum_word = DATA_W'(pend_sum);

  always_comb begin
    case (addr)
      ADDR_W'(OFF_DISP_STAT): rd_mux = DATA_W'(disp_stat);
      ADDR_W'(OFF_DISP_EN):   rd_mux = DATA_W'(disp_en);
      ADDR_W'(OFF_GFX_STAT):  rd_mux = DATA_W'(gfx_stat);
      ADDR_W'(OFF_GFX_EN):    rd_mux = DATA_W'(gfx_en);
      ADDR_W'(OFF_PWR_STAT):  rd_mux = DATA_W'(pwr_stat);
      ADDR_W'(OFF_PWR_EN):    rd_mux = DATA_W'(pwr_en);
      ADDR_W'(OFF_CTRL): begin
        rd_mux       = sum_word;
        rd_mux[MBIT] = master_q;
      end
      ADDR_W'(OFF_PEEK):      rd_mux = sum_word;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (hit_ctrl) master_q <= wdata[MBIT];
      if (rd_en)    rdata_q  <= rd_mux;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_edge_aggregator.sv
module irq_edge_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned DISP_W = 8,
  parameter int unsigned GFX_W  = 8,
  parameter int unsigned PWR_W  = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DISP_W-1:0] disp_evt,
  input  logic [GFX_W-1:0]  gfx_evt,
  input  logic [PWR_W-1:0]  pwr_evt,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_irq
);
  logic [DISP_W-1:0] disp_stat, disp_en_r, disp_clr;
  logic [GFX_W-1:0]  gfx_stat, gfx_en_r, gfx_clr;
  logic [PWR_W-1:0]  pwr_stat, pwr_en_r, pwr_clr;
  logic              disp_en_we, gfx_en_we, pwr_en_we;
  logic              disp_pend, gfx_pend, pwr_pend;
  logic              master_q, lvl_now, lvl_q, lvl_prev;

  irqagg_grp #(.W(DISP_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .evt_i(disp_evt), .clr_i(disp_clr),
    .en_we_i(disp_en_we), .en_d_i(reg_wdata[DISP_W-1:0]),
    .stat_o(disp_stat), .en_o(disp_en_r), .pend_o(disp_pend));

  irqagg_grp #(.W(GFX_W)) u_gfx (
    .clk(clk), .rst_n(rst_n), .evt_i(gfx_evt), .clr_i(gfx_clr),
    .en_we_i(gfx_en_we), .en_d_i(reg_wdata[GFX_W-1:0]),
    .stat_o(gfx_stat), .en_o(gfx_en_r), .pend_o(gfx_pend));

  irqagg_grp #(.W(PWR_W)) u_pwr (
    .clk(clk), .rst_n(rst_n), .evt_i(pwr_evt), .clr_i(pwr_clr),
    .en_we_i(pwr_en_we), .en_d_i(reg_wdata[PWR_W-1:0]),
    .stat_o(pwr_stat), .en_o(pwr_en_r), .pend_o(pwr_pend));

  irqagg_regport #(.DISP_W(DISP_W), .GFX_W(GFX_W), .PWR_W(PWR_W),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata),
    .disp_stat(disp_stat), .disp_en(disp_en_r),
    .gfx_stat(gfx_stat), .gfx_en(gfx_en_r),
    .pwr_stat(pwr_stat), .pwr_en(pwr_en_r),
    .pend_sum({pwr_pend, gfx_pend, disp_pend}),
    .disp_clr(disp_clr), .gfx_clr(gfx_clr), .pwr_clr(pwr_clr),
    .disp_en_we(disp_en_we), .gfx_en_we(gfx_en_we), .pwr_en_we(pwr_en_we),
    .master_q(master_q), .rdata(reg_rdata));

  assign lvl_now = combine_level(disp_pend, gfx_pend, pwr_pend, master_q);

  irqagg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_now),
    .lvl_q(lvl_q), .lvl_prev_q(lvl_prev), .irq_o(cpu_irq));
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_irq,
  input logic          lvl_q,
  input logic          master,
  input logic          disp_pend,
  input logic          gfx_pend,
  input logic          pwr_pend,
  input logic [DW-1:0] disp_en,
  input logic [DW-1:0] disp_evt,
  input logic [DW-1:0] disp_stat
);
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $rose(lvl_q));

  a_r2_disp_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    disp_pend |=> lvl_q);

  a_r1_gated_groups: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (gfx_pend || pwr_pend)) |=> lvl_q);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && (disp_en == '0)) |=> !lvl_q);

  a_r4_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_evt != '0) |=> ((disp_stat & $past(disp_evt)) == $past(disp_evt)));
endmodule

bind irq_edge_aggregator irqagg_chk #(.DW(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .lvl_q(lvl_q),
  .master(master_q), .disp_pend(disp_pend), .gfx_pend(gfx_pend),
  .pwr_pend(pwr_pend), .disp_en(disp_en_r), .disp_evt(disp_evt),
  .disp_stat(disp_stat));

// File: tb/tb_irq_edge_aggregator.sv
module tb_irq_edge_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, GW = 8, PW = 4, AW = 4, XW = 32;

  typedef struct {
    int          req;
    logic [31:0] exp;
    string       what;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] disp_evt = '0;
  logic [GW-1:0] gfx_evt = '0;
  logic [PW-1:0] pwr_evt = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rd_flag = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [XW-1:0] wdata = '0;
  logic [XW-1:0] rdata;
  logic          cpu_irq, irq_last = 1'b0;
  int            n_vec = 0, n_bad = 0, irq_cnt = 0, long_pulse = 0;
  bit            done = 0;
  item_t         sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_aggregator #(.DISP_W(DW), .GFX_W(GW), .PWR_W(PW), .ADDR_W(AW),
                        .DATA_W(XW)) dut (
    .clk(clk), .rst_n(rst_n), .disp_evt(disp_evt), .gfx_evt(gfx_evt),
    .pwr_evt(pwr_evt), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .cpu_irq(cpu_irq));

  // Monitor: one read result per strobed cycle, compared against the queue.
  always @(posedge clk) rd_flag <= rd_en;
  always @(negedge clk) begin
    if (rd_flag && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (rdata !== it.exp) begin
        n_bad++;
        $display("FAIL R%0d %s: actual %h expected %h", it.req, it.what, rdata, it.exp);
      end
    end
    if (cpu_irq) irq_cnt++;
    if (cpu_irq && irq_last) long_pulse++;
    irq_last = cpu_irq;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input int req, input string w);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    it.req = req; it.exp = e; it.what = w;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int grp, input logic [7:0] m);
    @(negedge clk);
    if (grp == 0) disp_evt = m; else if (grp == 1) gfx_evt = m; else pwr_evt = PW'(m);
    @(negedge clk);
    disp_evt = '0; gfx_evt = '0; pwr_evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input int e, input int req, input string w);
    n_vec++;
    if (irq_cnt != e) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d pulses", req, w, irq_cnt, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: everything cleared at reset
    for (int a = 0; a < 8; a++) rd(a, 32'h0, 8, "reset value");
    idle(3);
    chk_irq(0, 8, "no pulse after reset");

    // R4: disabled display event still latches; R1: no pulse while not enabled
    pulse(0, 8'h05);
    rd(0, 32'h05, 4, "display status sticky");
    idle(3);
    chk_irq(0, 1, "set but disabled");

    // R1/R3: enabling makes the edge, one pulse; level stays high afterwards
    wr(1, 32'h01);
    idle(4);
    chk_irq(1, 1, "display enabled edge");
    idle(10);
    chk_irq(1, 3, "held level no repeat");

    // R2: graphics gated off by master=0
    wr(3, 32'hFF);
    pulse(1, 8'h10);
    idle(4);
    chk_irq(1, 2, "graphics gated by master");
    rd(7, 32'h3, 7, "summary peek");

    // R6 order A: mask both, ack display, restore master first
    wr(1, 32'h00);
    wr(0, 32'h05);
    idle(2);
    wr(6, 32'h8000_0000);
    idle(4);
    chk_irq(2, 6, "residual graphics after master restore");
    wr(1, 32'h01);
    idle(4);
    chk_irq(2, 6, "display restore second no extra pulse");

    // R6 order B: display residual, restore display enable first
    pulse(0, 8'h01);
    wr(6, 32'h0);
    wr(1, 32'h00);
    idle(2);
    wr(1, 32'h01);
    idle(4);
    chk_irq(3, 6, "residual display after enable restore");
    wr(6, 32'h8000_0000);
    idle(4);
    chk_irq(3, 6, "master restore second no extra pulse");

    // R7: control word vs peek
    rd(6, 32'h8000_0003, 7, "control word");
    rd(7, 32'h0000_0003, 7, "peek masks master");

    // R4: write-one-to-clear; writing zeros keeps bits
    wr(6, 32'h0);
    wr(1, 32'h00);
    wr(2, 32'h0);
    rd(2, 32'h10, 4, "zero write keeps status");
    wr(2, 32'h10);
    wr(0, 32'h01);
    rd(2, 32'h0, 4, "graphics acked");
    rd(0, 32'h0, 4, "display acked");

    // R5: set and clear on the same bit in the same cycle
    pulse(0, 8'h02);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(0); wdata = 32'h02; disp_evt = 8'h02;
    @(negedge clk);
    wr_en = 1'b0; disp_evt = '0;
    rd(0, 32'h02, 5, "set wins over clear");
    wr(0, 32'h02);
    rd(0, 32'h0, 5, "later clear works");

    // R2: power group behind master
    wr(6, 32'h8000_0000);
    wr(5, 32'h1);
    pulse(2, 8'h08);
    rd(4, 32'h08, 4, "power status sticky");
    idle(3);
    chk_irq(3, 1, "power not enabled");
    wr(5, 32'h8);
    idle(4);
    chk_irq(4, 2, "power with master");

    // R7 write zero drops gated groups; R2 display still fires with master off
    wr(6, 32'h0);
    idle(3);
    wr(1, 32'h02);
    pulse(0, 8'h02);
    idle(4);
    chk_irq(5, 2, "display with master off");
    rd(7, 32'h5, 7, "peek display+power");

    // R9: peek write ignored, enable width, unmapped offset
    wr(7, 32'hFFFF_FFFF);
    rd(6, 32'h0000_0005, 9, "peek write ignored");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h0000_00FF, 9, "enable upper bits read 0");
    wr(9, 32'hFFFF_FFFF);
    rd(9, 32'h0, 9, "unmapped offset");
    rd(5, 32'h8, 9, "unmapped write left power enable");
    idle(4);
    chk_irq(5, 3, "no pulse while level held");

    n_vec++;
    if (long_pulse != 0) begin
      n_bad++;
      $display("FAIL R3 pulse width: actual %0d long pulses expected 0", long_pulse);
    end
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule